// File: doc/BRIEF.md
# Transmit Buffer Descriptor Engine

This block keeps a table of transmit buffer descriptors and serves them in ring order on behalf of a host. The host fills a descriptor with a buffer address, a frame length and control flags, then hands it over by setting its ready bit. While transmission is enabled, the engine looks at the descriptor at its current ring index. When that descriptor is ready, it offers the buffer address, length and per-frame options to a MAC transmit port. After the MAC reports that the frame is finished, the engine writes the outcome back into the descriptor, clears the ready bit so that the host owns the descriptor again, and may latch an interrupt source.

The MAC request is a valid/ready stream. Once `mac_valid` is high, it stays high and the address, length, pad and CRC outputs hold their values until the cycle in which `mac_ready` is sampled high. At most one request is outstanding. The MAC then pulses `mac_done` for one cycle with the frame's result on the status inputs; `mac_done` is only honoured after the request has been accepted. The host reaches everything through a 32-bit register bus. Writes take effect on the clock edge. Read data is combinational from `bus_addr`, and addresses that are not word-aligned or not mapped read as zero.

Top module: `txbd_engine`

## Requirements
- R1: After reset, `mac_valid` and `irq` are 0. The mode, interrupt source and interrupt mask registers read 0, the ring-size register reads NUM_SLOTS, and every descriptor word reads 0.
- R2: The registers are mapped as follows:
  - 0x00 holds the mode register; bit 1 is transmit enable.
  - 0x04 holds the interrupt sources in bits 1:0.
  - 0x08 holds the interrupt mask in bits 1:0.
  - 0x0C holds the ring size. A write above NUM_SLOTS stores NUM_SLOTS.
  - Descriptor i occupies 0x400+8*i. The status word is at +0 and the buffer address at +4.
  - Descriptors at or beyond the ring size read 0, and writes to them are ignored.
- R3: Status word fields:
  - bits 31:16: length
  - bit 15: ready
  - bit 14: interrupt enable
  - bit 13: wrap
  - bit 12: pad
  - bit 11: CRC
  - bit 8: underrun
  - bits 7:4: retries
  - bit 3: retry limit
  - bit 2: late collision
  - bit 1: deferred
  - bit 0: carrier lost

  For a ready descriptor at the ring index, `mac_buf_addr`, `mac_len`, `mac_pad` and `mac_crc` carry its address word, bits 31:16, bit 12 and bit 11. They stay stable with `mac_valid` until accepted.
- R4: On `mac_done`, the served status word gets bit 15 cleared. Bits 8..0 are loaded from underrun, retries, retry limit, late collision, deferred and carrier lost. Bits 31:16 and 14:9 keep their values.
- R5: After serving a descriptor with bit 13 set, the ring index returns to 0. Otherwise it advances by one, and returns to 0 when the next index would reach the ring size.
- R6: While the descriptor at the ring index has bit 15 clear, no request is made and later descriptors are not skipped to. Once the host sets bit 15, service resumes at that index.
- R7: A completion whose descriptor has bit 14 set latches source bit 0 when none of underrun, retry limit, late collision or carrier lost is reported, and source bit 1 otherwise. Deferral and retry count alone are not errors. With bit 14 clear, no source bit is set.
- R8: Source bits latch whether or not they are masked, and hold until the host writes 1 to them at 0x04. A bit being set in the same cycle as it is cleared stays set.
- R9: `irq` is high exactly when some source bit and the same mask bit are both 1.
- R10: Requests start only while transmit enable is 1. Clearing it lets an accepted transmit complete and write back, and then the ring index returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mac_valid | output | 1 | Transmit request valid |
| mac_ready | input | 1 | MAC accepts the request |
| mac_buf_addr | output | 32 | Buffer address of the frame |
| mac_len | output | 16 | Frame length |
| mac_pad | output | 1 | Pad short frame |
| mac_crc | output | 1 | Append CRC |
| mac_done | input | 1 | One-cycle completion pulse |
| mac_retries | input | 4 | Retry count of the completed frame |
| mac_underrun | input | 1 | Underrun occurred |
| mac_retry_limit | input | 1 | Retry limit reached |
| mac_late_coll | input | 1 | Late collision |
| mac_deferred | input | 1 | Transmission was deferred |
| mac_carrier_lost | input | 1 | Carrier sense lost |
| irq | output | 1 | Interrupt request |

## Verification
The ring is tried with several descriptor patterns:
- A wrap flag on the second slot separates flag-driven wrapping from size-driven wrapping.
- A gap in the ready bits, with a later slot already ready, separates waiting in place from skipping ahead.
- A run that goes to the last slot of a shortened ring shows the return to slot 0 at the size boundary.
- Completions carrying deferral and retries, underrun, or collision with retry limit, with the interrupt-enable bit on and off, separate the good and error sources from each other and from the no-interrupt case.
- Back-pressure on `mac_ready` tests the hold rule.
- Disabling transmission while a frame is in flight shows that the completion still lands and that service resumes at slot 0 rather than at the next slot.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
  // control register byte offsets
  localparam int OFS_MODE  = 'h00;
  localparam int OFS_SRC   = 'h04;
  localparam int OFS_MASK  = 'h08;
  localparam int OFS_COUNT = 'h0C;
  // descriptor table base, 8 bytes per entry
  localparam int TABLE_BASE = 'h400;

  // status bits kept on completion: length and control fields
  localparam logic [31:0] KEEP_MASK = 32'hFFFF_7E00;

  // layout equals status word bits 8:0
  typedef struct packed {
    logic       underrun;
    logic [3:0] retries;
    logic       retry_limit;
    logic       late_coll;
    logic       deferred;
    logic       carrier_lost;
  } tx_result_t;

  // status bits 15:11 as seen by the ring sequencer
  typedef struct packed {
    logic ready;
    logic irq_en;
    logic wrap;
    logic pad;
    logic crc;
  } desc_flags_t;

  typedef enum logic [1:0] {RING_IDLE, RING_REQ, RING_WAIT} ring_state_e;
endpackage

// File: rtl/txbd_table.sv
module txbd_table import txbd_pkg::*; #(
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 12,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic [CNT_W-1:0]  ring_count,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic [15:0]       cur_len,
  output desc_flags_t       cur_flags,
  output logic [31:0]       cur_addr,
  input  logic              wb_en,
  input  tx_result_t        wb_result
);
  localparam int SW = ADDR_W - 3;

  logic [SW-1:0] slot_sel;
  logic          in_tbl;
  logic          word_hi;
  logic [31:0]   stat_w [NUM_SLOTS];
  logic [31:0]   addr_w [NUM_SLOTS];

  assign slot_sel = host_addr[ADDR_W-1:3] - SW'(TABLE_BASE >> 3);
  assign word_hi  = host_addr[2];
  assign in_tbl   = (host_addr >= ADDR_W'(TABLE_BASE)) && (host_addr[1:0] == 2'b00)
                    && (32'(slot_sel) < 32'(ring_count));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic        sel;
    logic [31:0] stat_r, addr_r;
    assign sel = in_tbl && (slot_sel == SW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_r <= '0;
        addr_r <= '0;
      end else begin
        // completion write-back has priority over a host write
        if (wb_en && cur_idx == IDX_W'(g))
          stat_r <= (stat_r & KEEP_MASK) | 32'(wb_result);
        else if (host_wr && sel && !word_hi)
          stat_r <= host_wdata;
        if (host_wr && sel && word_hi)
          addr_r <= host_wdata;
      end
    end
    assign stat_w[g] = stat_r;
    assign addr_w[g] = addr_r;
  end

  always_comb begin
    host_rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (in_tbl && slot_sel == SW'(i))
        host_rdata = word_hi ? addr_w[i] : stat_w[i];
  end

  always_comb begin
    cur_len   = '0;
    cur_flags = '0;
    cur_addr  = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (cur_idx == IDX_W'(i)) begin
        cur_len   = stat_w[i][31:16];
        cur_flags = stat_w[i][15:11];
        cur_addr  = addr_w[i];
      end
  end
endmodule

// File: rtl/txbd_irq.sv
module txbd_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mask_wr,
  input  logic       src_clr_wr,
  input  logic [1:0] wdata,
  input  logic       set_good,
  input  logic       set_err,
  output logic [1:0] irq_src,
  output logic [1:0] irq_mask,
  output logic       irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_src  <= '0;
      irq_mask <= '0;
    end else begin
      irq_src <= (irq_src & ~(src_clr_wr ? wdata : 2'b00)) | {set_err, set_good};
      if (mask_wr) irq_mask <= wdata;
    end
  end

  assign irq = |(irq_src & irq_mask);
endmodule

// File: rtl/txbd_ring.sv
module txbd_ring import txbd_pkg::*; #(
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [CNT_W-1:0] ring_count,
  input  logic [15:0]      cur_len,
  input  desc_flags_t      cur_flags,
  input  logic [31:0]      cur_addr,
  output logic [IDX_W-1:0] cur_idx,
  output logic             busy,
  output logic             mac_valid,
  input  logic             mac_ready,
  output logic [31:0]      mac_buf_addr,
  output logic [15:0]      mac_len,
  output logic             mac_pad,
  output logic             mac_crc,
  input  logic             mac_done,
  input  logic             done_err,
  output logic             wb_en,
  output logic             set_good,
  output logic             set_err
);
  ring_state_e      state_q;
  logic             wrap_q, irqen_q;
  logic [IDX_W-1:0] next_idx;
  logic             slot_ok;

  assign slot_ok  = 32'(cur_idx) < 32'(ring_count);
  assign next_idx = (wrap_q || (32'(cur_idx) + 1 >= 32'(ring_count))) ? '0 : cur_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= RING_IDLE;
      cur_idx      <= '0;
      wrap_q       <= 1'b0;
      irqen_q      <= 1'b0;
      mac_buf_addr <= '0;
      mac_len      <= '0;
      mac_pad      <= 1'b0;
      mac_crc      <= 1'b0;
    end else begin
      case (state_q)
        RING_IDLE: begin
          if (!tx_en) begin
            cur_idx <= '0;
          end else if (slot_ok && cur_flags.ready) begin
            mac_buf_addr <= cur_addr;
            mac_len      <= cur_len;
            mac_pad      <= cur_flags.pad;
            mac_crc      <= cur_flags.crc;
            wrap_q       <= cur_flags.wrap;
            irqen_q      <= cur_flags.irq_en;
            state_q      <= RING_REQ;
          end
        end
        RING_REQ:  if (mac_ready) state_q <= RING_WAIT;
        RING_WAIT: if (mac_done) begin
          cur_idx <= next_idx;
          state_q <= RING_IDLE;
        end
        default:   state_q <= RING_IDLE;
      endcase
    end
  end

  assign mac_valid = (state_q == RING_REQ);
  assign busy      = (state_q != RING_IDLE);
  assign wb_en     = (state_q == RING_WAIT) && mac_done;
  assign set_good  = wb_en && irqen_q && !done_err;
  assign set_err   = wb_en && irqen_q && done_err;
endmodule

// File: rtl/txbd_engine.sv
module txbd_engine import txbd_pkg::*; #(
  parameter  int NUM_SLOTS = 8,
  parameter  int ADDR_W    = 12,
  localparam int IDX_W     = $clog2(NUM_SLOTS),
  localparam int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mac_valid,
  input  logic              mac_ready,
  output logic [31:0]       mac_buf_addr,
  output logic [15:0]       mac_len,
  output logic              mac_pad,
  output logic              mac_crc,
  input  logic              mac_done,
  input  logic [3:0]        mac_retries,
  input  logic              mac_underrun,
  input  logic              mac_retry_limit,
  input  logic              mac_late_coll,
  input  logic              mac_deferred,
  input  logic              mac_carrier_lost,
  output logic              irq
);
  logic             tx_en;
  logic [CNT_W-1:0] ring_count;
  logic [1:0]       irq_src, irq_mask;
  logic [IDX_W-1:0] cur_idx;
  logic             busy;
  logic [15:0]      cur_len;
  desc_flags_t      cur_flags;
  logic [31:0]      cur_addr, tbl_rdata;
  logic             wb_en, set_good, set_err, done_err;
  tx_result_t       result;
  logic             hit_mode, hit_src, hit_mask, hit_count;

  assign hit_mode  = bus_addr == ADDR_W'(OFS_MODE);
  assign hit_src   = bus_addr == ADDR_W'(OFS_SRC);
  assign hit_mask  = bus_addr == ADDR_W'(OFS_MASK);
  assign hit_count = bus_addr == ADDR_W'(OFS_COUNT);

  assign result   = {mac_underrun, mac_retries, mac_retry_limit, mac_late_coll,
                     mac_deferred, mac_carrier_lost};
  assign done_err = mac_underrun | mac_retry_limit | mac_late_coll | mac_carrier_lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en      <= 1'b0;
      ring_count <= CNT_W'(NUM_SLOTS);
    end else if (bus_wr) begin
      if (hit_mode) tx_en <= bus_wdata[1];
      if (hit_count)
        ring_count <= (bus_wdata > 32'(NUM_SLOTS)) ? CNT_W'(NUM_SLOTS) : bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = tbl_rdata;
    if (hit_mode)       bus_rdata = {30'b0, tx_en, 1'b0};
    else if (hit_src)   bus_rdata = {30'b0, irq_src};
    else if (hit_mask)  bus_rdata = {30'b0, irq_mask};
    else if (hit_count) bus_rdata = 32'(ring_count);
  end

  txbd_table #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .host_wr(bus_wr), .host_addr(bus_addr),
    .host_wdata(bus_wdata), .host_rdata(tbl_rdata), .ring_count(ring_count),
    .cur_idx(cur_idx), .cur_len(cur_len), .cur_flags(cur_flags), .cur_addr(cur_addr),
    .wb_en(wb_en), .wb_result(result)
  );

  txbd_ring #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ring_count(ring_count),
    .cur_len(cur_len), .cur_flags(cur_flags), .cur_addr(cur_addr),
    .cur_idx(cur_idx), .busy(busy), .mac_valid(mac_valid), .mac_ready(mac_ready),
    .mac_buf_addr(mac_buf_addr), .mac_len(mac_len), .mac_pad(mac_pad), .mac_crc(mac_crc),
    .mac_done(mac_done), .done_err(done_err), .wb_en(wb_en),
    .set_good(set_good), .set_err(set_err)
  );

  txbd_irq u_irq (
    .clk(clk), .rst_n(rst_n), .mask_wr(bus_wr && hit_mask),
    .src_clr_wr(bus_wr && hit_src), .wdata(bus_wdata[1:0]),
    .set_good(set_good), .set_err(set_err),
    .irq_src(irq_src), .irq_mask(irq_mask), .irq(irq)
  );
endmodule

// File: rtl/txbd_engine_chk.sv
module txbd_engine_chk #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mac_valid,
  input logic              mac_ready,
  input logic [31:0]       mac_buf_addr,
  input logic [15:0]       mac_len,
  input logic              tx_en,
  input logic              busy,
  input logic [IDX_W-1:0]  cur_idx,
  input logic              irq,
  input logic [1:0]        irq_mask,
  input logic [1:0]        irq_src,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        src_wdata
);
  // R3: request held stable under back-pressure
  a_r3_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_valid && !mac_ready) |=> (mac_valid && $stable(mac_buf_addr) && $stable(mac_len)));

  // R8: a latched source bit survives until written with 1
  a_r8_src0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src[0] && !(bus_wr && bus_addr == ADDR_W'(4) && src_wdata[0])) |=> irq_src[0]);
  a_r8_src1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src[1] && !(bus_wr && bus_addr == ADDR_W'(4) && src_wdata[1])) |=> irq_src[1]);

  // R9: no interrupt while everything is masked
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 2'b00) |-> !irq);

  // R10: no new request while disabled, index returns to 0 when idle
  a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !mac_valid) |=> !mac_valid);
  a_r10_idx_home: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> (cur_idx == '0));
endmodule

bind txbd_engine txbd_engine_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mac_valid(mac_valid), .mac_ready(mac_ready),
  .mac_buf_addr(mac_buf_addr), .mac_len(mac_len), .tx_en(tx_en), .busy(busy),
  .cur_idx(cur_idx), .irq(irq), .irq_mask(irq_mask), .irq_src(irq_src),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .src_wdata(bus_wdata[1:0])
);

// File: tb/txbd_engine_bench.sv
module txbd_engine_bench;
  localparam int NS = 8;
  localparam int AW = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          mac_valid, mac_ready, mac_pad, mac_crc, mac_done;
  logic [31:0]   mac_buf_addr;
  logic [15:0]   mac_len;
  logic [3:0]    mac_retries;
  logic          mac_underrun, mac_retry_limit, mac_late_coll, mac_deferred, mac_carrier_lost;
  logic          irq;

  txbd_engine #(.NUM_SLOTS(NS), .ADDR_W(AW)) u_txbd_engine (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mac_valid(mac_valid),
    .mac_ready(mac_ready), .mac_buf_addr(mac_buf_addr), .mac_len(mac_len),
    .mac_pad(mac_pad), .mac_crc(mac_crc), .mac_done(mac_done),
    .mac_retries(mac_retries), .mac_underrun(mac_underrun),
    .mac_retry_limit(mac_retry_limit), .mac_late_coll(mac_late_coll),
    .mac_deferred(mac_deferred), .mac_carrier_lost(mac_carrier_lost), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  int stall_cycles = 0;
  int done_lat = 2;
  logic [49:0] exp_q[$];
  logic [8:0]  resp_q[$];
  logic [31:0] orig[NS];

  task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wb(input logic [31:0] o, input logic [8:0] r);
    return (o & 32'hFFFF_7E00) | {23'b0, r};
  endfunction

  function automatic logic [AW-1:0] st_a(input int s);
    return AW'('h400 + 8 * s);
  endfunction

  function automatic logic [31:0] mk(input logic [15:0] len, input logic ie,
                                     input logic wr, input logic pd, input logic cr);
    return {len, 1'b1, ie, wr, pd, cr, 11'b0};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic prog(input int s, input logic [31:0] a, input logic [31:0] st);
    orig[s] = st;
    wr(st_a(s) + AW'(4), a);
    wr(st_a(s), st);
  endtask

  task automatic expect_tx(input logic [31:0] a, input logic [31:0] st, input logic [8:0] r);
    exp_q.push_back({a, st[31:16], st[12], st[11]});
    resp_q.push_back(r);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // MAC model and scoreboard monitor
  initial begin
    int stall_cnt;
    logic [8:0] r;
    stall_cnt = 0;
    mac_ready = 1'b0; mac_done = 1'b0;
    {mac_underrun, mac_retries, mac_retry_limit, mac_late_coll, mac_deferred, mac_carrier_lost} = '0;
    forever begin
      @(negedge clk);
      mac_done = 1'b0;
      if (mac_ready) begin
        mac_ready = 1'b0;
        repeat (done_lat) @(negedge clk);
        if (resp_q.size() == 0) begin
          r = '0;
          check_eq("R6 completion without expected frame", 1, 0);
        end else r = resp_q.pop_front();
        {mac_underrun, mac_retries, mac_retry_limit, mac_late_coll, mac_deferred, mac_carrier_lost} = r;
        mac_done = 1'b1;
      end else if (mac_valid && rst_n) begin
        if (stall_cnt < stall_cycles) stall_cnt++;
        else begin
          stall_cnt = 0;
          if (exp_q.size() == 0)
            check_eq("R6 unexpected request", 64'(mac_buf_addr), 64'hFFFF_FFFF);
          else
            check_eq("R3 R10 request content and order",
                     64'({mac_buf_addr, mac_len, mac_pad, mac_crc}), 64'(exp_q.pop_front()));
          mac_ready = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] s0, s1, s2, s3;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < NS; i++) orig[i] = '0;
    wait_cyc(3);
    rst_n = 1'b1;

    // R1 reset state
    check_eq("R1 mac_valid", 64'(mac_valid), 0);
    check_eq("R1 irq", 64'(irq), 0);
    rd(AW'('h00), d); check_eq("R1 mode", 64'(d), 0);
    rd(AW'('h04), d); check_eq("R1 source", 64'(d), 0);
    rd(AW'('h08), d); check_eq("R1 mask", 64'(d), 0);
    rd(AW'('h0C), d); check_eq("R1 ring size", 64'(d), NS);
    rd(st_a(0), d);   check_eq("R1 descriptor 0", 64'(d), 0);

    // R2 register map and size clamp
    wr(AW'('h0C), 200);
    rd(AW'('h0C), d); check_eq("R2 size clamp", 64'(d), NS);
    wr(AW'('h0C), 4);
    rd(AW'('h0C), d); check_eq("R2 size 4", 64'(d), 4);
    wr(st_a(2) + AW'(4), 32'hCAFE_0010);
    rd(st_a(2) + AW'(4), d); check_eq("R2 address word", 64'(d), 64'hCAFE_0010);
    wr(AW'('h08), 3);
    rd(AW'('h08), d); check_eq("R2 mask readback", 64'(d), 3);

    // R3 R4 R5 R7: wrap flag on slot 1
    s0 = mk(16'h003C, 1, 0, 0, 1);
    s1 = mk(16'h0040, 1, 1, 1, 0);
    stall_cycles = 1; done_lat = 2;
    expect_tx(32'h0000_1000, s0, 9'h022);
    expect_tx(32'h0000_2000, s1, 9'h100);
    prog(0, 32'h0000_1000, s0);
    prog(1, 32'h0000_2000, s1);
    wr(AW'('h00), 2);
    rd(AW'('h00), d); check_eq("R2 mode readback", 64'(d), 2);
    wait_cyc(60);
    rd(st_a(0), d); check_eq("R4 slot0 write-back", 64'(d), 64'(wb(s0, 9'h022)));
    rd(st_a(1), d); check_eq("R4 slot1 write-back", 64'(d), 64'(wb(s1, 9'h100)));
    rd(AW'('h04), d); check_eq("R7 good and error sources", 64'(d), 3);
    check_eq("R9 irq with mask 3", 64'(irq), 1);
    check_eq("R5 R6 idle at slot0 after wrap", 64'(mac_valid), 0);
    check_eq("R3 queue drained", 64'(exp_q.size()), 0);

    // R8 R9 latch, mask and clear
    wr(AW'('h08), 0);
    check_eq("R9 masked irq", 64'(irq), 0);
    rd(AW'('h04), d); check_eq("R8 sources kept while masked", 64'(d), 3);
    wr(AW'('h04), 1);
    rd(AW'('h04), d); check_eq("R8 clear bit0 only", 64'(d), 2);
    wr(AW'('h08), 2);
    check_eq("R9 irq from bit1", 64'(irq), 1);
    wr(AW'('h04), 2);
    check_eq("R9 irq after clear", 64'(irq), 0);

    // R7 interrupt enable clear, R5 wrap resumed at slot0
    s0 = mk(16'h0050, 0, 0, 0, 1);
    expect_tx(32'h0000_3000, s0, 9'h010);
    prog(0, 32'h0000_3000, s0);
    wait_cyc(30);
    rd(st_a(0), d); check_eq("R4 slot0 second write-back", 64'(d), 64'(wb(s0, 9'h010)));
    rd(AW'('h04), d); check_eq("R7 no source without enable", 64'(d), 0);

    // R6 gap: slot1 not ready, slot2 ready
    s2 = mk(16'h0100, 0, 0, 0, 0);
    prog(2, 32'h0000_5000, s2);
    wait_cyc(10);
    check_eq("R6 no skip past unready slot", 64'(mac_valid), 0);
    s1 = mk(16'h0044, 1, 0, 0, 1);
    s3 = mk(16'h0200, 1, 0, 1, 1);
    stall_cycles = 3;
    expect_tx(32'h0000_4000, s1, 9'h000);
    expect_tx(32'h0000_5000, s2, 9'h00C);
    expect_tx(32'h0000_6000, s3, 9'h0F2);
    prog(3, 32'h0000_6000, s3);
    prog(1, 32'h0000_4000, s1);
    wait_cyc(80);
    rd(st_a(1), d); check_eq("R4 slot1 good", 64'(d), 64'(wb(s1, 9'h000)));
    rd(st_a(2), d); check_eq("R4 slot2 collision", 64'(d), 64'(wb(s2, 9'h00C)));
    rd(st_a(3), d); check_eq("R4 slot3 retries", 64'(d), 64'(wb(s3, 9'h0F2)));
    rd(AW'('h04), d); check_eq("R7 deferral not error, disabled error silent", 64'(d), 1);
    check_eq("R6 queue drained", 64'(exp_q.size()), 0);
    wr(AW'('h04), 3);

    // R5 size wrap to slot0, R10 disable while in flight
    stall_cycles = 0; done_lat = 10;
    s0 = mk(16'h0060, 1, 0, 0, 1);
    expect_tx(32'h0000_7000, s0, 9'h000);
    prog(0, 32'h0000_7000, s0);
    wr(AW'('h00), 0);
    wait_cyc(20);
    rd(st_a(0), d); check_eq("R10 R5 in-flight completes after disable", 64'(d), 64'(wb(s0, 9'h000)));
    check_eq("R5 served slot0 after size wrap", 64'(exp_q.size()), 0);
    s1 = mk(16'h0070, 0, 0, 0, 0);
    s0 = mk(16'h0080, 0, 0, 1, 0);
    prog(1, 32'h0000_8000, s1);
    prog(0, 32'h0000_9000, s0);
    wait_cyc(10);
    check_eq("R10 no request while disabled", 64'(mac_valid), 0);
    done_lat = 1;
    expect_tx(32'h0000_9000, s0, 9'h000);
    expect_tx(32'h0000_8000, s1, 9'h000);
    wr(AW'('h00), 2);
    wait_cyc(60);
    check_eq("R10 resumed at slot0", 64'(exp_q.size()), 0);
    rd(st_a(1), d); check_eq("R10 slot1 served", 64'(d), 64'(wb(s1, 9'h000)));

    // R2 slot beyond ring size ignored
    wr(st_a(5), 32'hDEAD_8000);
    rd(st_a(5), d); check_eq("R2 slot beyond size", 64'(d), 0);
    wait_cyc(10);
    check_eq("R2 no request from slot beyond size", 64'(mac_valid), 0);
    check_eq("R4 all completions consumed", 64'(resp_q.size()), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule